// File: doc/BRIEF.md
# Table-Driven Wall-Following Robot Controller

This block steers a walking robot with two antennae through a maze. The strategy is to keep the right antenna on a wall. Each enabled step reads a left and a right contact input. It then issues a forward-step command and ten-degree left or right turn commands.

The whole behaviour comes from one 16-word by 5-bit lookup table. The table is addressed by the 2-bit current state and the two contact inputs. Each word supplies the next state and the three command bits. The full word is captured in one register bank, so state and commands change together, and only on a clock edge where the step strobe is high.

Because the word is captured whole, the commands seen after a step are the ones that belong to the state the step left. The motor drivers downstream take commands once per step.

Top module: `wallbot_lut_ctrl`

## Requirements
- R1: A synchronous reset puts the state in Lost (code 00) and sets the commands {turn_r,turn_l,fwd} to 001, forward only.
- R2: On a clock edge with step_en low and reset low, the state and all three commands keep their values, whatever the contact inputs do.
- R3: From Lost (00), an enabled step with neither antenna touching stays in Lost. Contact on either antenna moves the state to rotate-left (01).
- R4: From rotate-left (01), an enabled step stays in 01 while either antenna touches. With no contact it moves to Wall1 (10).
- R5: From Wall1 (10), ant_l has no effect. An enabled step stays in 10 when ant_r=0 and moves to Wall2 (11) when ant_r=1.
- R6: From Wall2 (11), an enabled step with ant_l=1 moves to 01. With ant_l=0 it moves to 10 when ant_r=0 and stays in 11 when ant_r=1.
- R7: After an enabled step, {turn_r,turn_l,fwd} shows the commands of the state just left: Lost 001, rotate-left 010, Wall1 101, Wall2 011.
- R8: turn_r and turn_l are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance strobe; state and commands load only when high |
| ant_l | input | 1 | Left antenna contact |
| ant_r | input | 1 | Right antenna contact |
| turn_r | output | 1 | Ten-degree right turn command |
| turn_l | output | 1 | Ten-degree left turn command |
| fwd | output | 1 | Forward step command |
| state_o | output | 2 | Current state code |

## Verification
A directed pass visits every state under all four contact patterns. This separates the one-antenna cases from the both-antenna and no-contact cases, and it shows that ant_l is ignored in Wall1 while it matters in Wall2. Idle stretches toggle the contacts with step_en low, which separates holding from stepping. A long random stream then mixes steps, holds and resets mid-walk, and each cycle is compared against a behavioural model of the transitions and commands.

// File: rtl/wallbot_lut_ctrl.sv
module wallbot_lut_ctrl #(
  parameter int ST_W  = 2,
  parameter int CMD_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_en,
  input  logic            ant_l,
  input  logic            ant_r,
  output logic            turn_r,
  output logic            turn_l,
  output logic            fwd,
  output logic [ST_W-1:0] state_o
);
  localparam int ADDR_W = ST_W + 2;
  localparam int WORD_W = ST_W + CMD_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [ST_W-1:0] S_LOST  = ST_W'(0);
  localparam logic [ST_W-1:0] S_RCCW  = ST_W'(1);
  localparam logic [ST_W-1:0] S_WALL1 = ST_W'(2);
  localparam logic [ST_W-1:0] S_WALL2 = ST_W'(3);
  localparam logic [CMD_W-1:0] CMD_RST = CMD_W'(1);

  function automatic logic [WORD_W-1:0] lut_word(input logic [ADDR_W-1:0] a);
    logic [ST_W-1:0]  s, nx;
    logic             l, r;
    logic [CMD_W-1:0] c;
    s = a[ADDR_W-1:2];
    l = a[1];
    r = a[0];
    case (s)
      S_LOST:  nx = (l | r) ? S_RCCW : S_LOST;
      S_RCCW:  nx = (l | r) ? S_RCCW : S_WALL1;
      S_WALL1: nx = r ? S_WALL2 : S_WALL1;
      default: nx = l ? S_RCCW : (r ? S_WALL2 : S_WALL1);
    endcase
    c    = '0;
    c[2] = (s == S_WALL1);
    c[1] = (s == S_RCCW) || (s == S_WALL2);
    c[0] = (s != S_RCCW);
    return {nx, c};
  endfunction

  logic [WORD_W-1:0] lut [DEPTH];
  for (genvar a = 0; a < DEPTH; a++) begin : g_lut
    assign lut[a] = lut_word(ADDR_W'(a));
  end

  logic [ST_W-1:0]  state_q;
  logic [CMD_W-1:0] cmd_q;

  always_ff @(posedge clk) begin
    if (rst)          {state_q, cmd_q} <= {S_LOST, CMD_RST};
    else if (step_en) {state_q, cmd_q} <= lut[{state_q, ant_l, ant_r}];
  end

  assign state_o = state_q;
  assign turn_r  = cmd_q[2];
  assign turn_l  = cmd_q[1];
  assign fwd     = cmd_q[0];

  p_reset_lost_r1: assert property (@(posedge clk)
    rst |=> (state_o == S_LOST && {turn_r, turn_l, fwd} == 3'b001));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(state_o) && $stable({turn_r, turn_l, fwd})));
  p_lost_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (step_en && state_o == S_LOST && !ant_l && !ant_r) |=> state_o == S_LOST);
  p_rccw_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (step_en && state_o == S_RCCW && !ant_l && !ant_r) |=> state_o == S_WALL1);
  p_wall1_r5: assert property (@(posedge clk) disable iff (rst)
    (step_en && state_o == S_WALL1) |=> state_o == ($past(ant_r) ? S_WALL2 : S_WALL1));
  p_wall2_left_r6: assert property (@(posedge clk) disable iff (rst)
    (step_en && state_o == S_WALL2 && ant_l) |=> state_o == S_RCCW);
  p_turns_excl_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({turn_r, turn_l}));
endmodule

// File: tb/wallbot_lut_ctrl_tb.sv
module wallbot_lut_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1, step_en = 1'b0, ant_l = 1'b0, ant_r = 1'b0;
  logic turn_r, turn_l, fwd;
  logic [1:0] state_o;
  int total = 0, bad = 0;
  int m_st = 0, m_cmd = 1;
  string st_tag = "R1", cmd_tag = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wallbot_lut_ctrl dut_i (.clk(clk), .rst(rst), .step_en(step_en), .ant_l(ant_l),
    .ant_r(ant_r), .turn_r(turn_r), .turn_l(turn_l), .fwd(fwd), .state_o(state_o));

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cmd = 1; st_tag = "R1"; cmd_tag = "R1";
    end else if (step_en) begin
      cmd_tag = "R7";
      case (m_st)
        0: begin m_cmd = 1; st_tag = "R3"; m_st = (ant_l || ant_r) ? 1 : 0; end
        1: begin m_cmd = 2; st_tag = "R4"; m_st = (ant_l || ant_r) ? 1 : 2; end
        2: begin m_cmd = 5; st_tag = "R5"; m_st = ant_r ? 3 : 2; end
        default: begin
          m_cmd = 3; st_tag = "R6";
          if (ant_l) m_st = 1; else m_st = ant_r ? 3 : 2;
        end
      endcase
    end else begin
      st_tag = "R2"; cmd_tag = "R2";
    end
  end

  task automatic check_now();
    total++;
    if (state_o !== 2'(m_st)) begin
      bad++;
      $display("FAIL %s state actual=%0d expected=%0d", st_tag, state_o, m_st);
    end
    total++;
    if ({turn_r, turn_l, fwd} !== 3'(m_cmd)) begin
      bad++;
      $display("FAIL %s cmd actual=%b expected=%b", cmd_tag, {turn_r, turn_l, fwd}, 3'(m_cmd));
    end
    total++;
    if (turn_r && turn_l) begin
      bad++;
      $display("FAIL R8 turns actual=11 expected=not both");
    end
  endtask

  task automatic cyc(input bit r, input bit e, input bit l, input bit rr);
    @(negedge clk);
    check_now();
    rst = r; step_en = e; ant_l = l; ant_r = rr;
  endtask

  task automatic reach(input int target);
    cyc(1, 0, 0, 0);
    if (target >= 1) cyc(0, 1, 1, 0);
    if (target >= 2) cyc(0, 1, 0, 0);
    if (target == 3) cyc(0, 1, 0, 1);
  endtask

  initial begin
    int seed = 17;
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);
    // R1 reset state, then R2 holds with contacts toggling
    cyc(0, 0, 1, 1);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 0, 1);
    // R3..R6, R7: every state under every contact pattern
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 4; p++) begin
        reach(s);
        cyc(0, 1, p[1], p[0]);
        cyc(0, 0, ~p[1], ~p[0]);
        cyc(0, 0, 0, 0);
      end
    end
    // random walk with holds and occasional resets
    for (int i = 0; i < 4000; i++) begin
      int v = $urandom(seed);
      seed = v;
      cyc((v[7:0] == 8'h5A), (v[9:8] != 2'b00), v[10], v[11]);
    end
    cyc(0, 0, 0, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule